// File: doc/BRIEF.md
# Head-Per-Track Disk Word Transfer Engine

This block moves a run of 12-bit words between a head-per-track disk store and main memory. It uses a three-cycle data break. The run length and the memory pointer are not held in the block. They live in two fixed words of memory field 0: the negated word count at octal 07750 and the current address at octal 07751. For every word, the engine reads each of those locations, adds one to it and writes it back. It then moves the data word to or from the physical address formed by the 3-bit field number above the new pointer.

A transfer begins with a start strobe. The strobe carries the direction and the full 20-bit disk address. The engine first waits until the addressed word is under the head, which it learns by comparing the head-position input with the low 11 address bits. It then moves words, either back to back in burst mode or one per word-time tick. Before each word it checks the disk address against the capacity given by the platter count. Every write is checked against a 32-bit lock mask indexed from the disk address. The run ends, and done is raised, when the incremented word count reaches zero or when an error bit is set.

Top module: `dk_dma_engine`

## Requirements
- R1: After reset, done is 1, busy is 0, both error outputs are 0 and no memory request is made.
- R2: A start strobe while idle loads the disk address from start_da, clears both errors and deasserts done on the next cycle. Busy stays high until the run ends. done and busy are never high together.
- R3: The first memory request of a run is issued exactly two cycles after the first cycle in which head_pos equals the low 11 bits of the disk address.
- R4: Each word makes four memory accesses in this order: a read of 07750, a write of that value plus one modulo 4096, a read of 07751, and a write of that value plus one modulo 4096. The data access follows them.
- R5: The physical memory address is {mex, incremented pointer}. When the pointer wraps from 4095 to 0, it stays in the same 4K field.
- R6: With start_write = 0, the disk word at the current disk address is written to memory. If the physical address is at or above PHYS_WORDS, the write is dropped, but both counters still advance.
- R7: With start_write = 1, the memory word is read and then written to the disk at the current disk address. The exception is when lock bit {da[19:18], da[16:14]} of wlock_mask is set. In that case err_wlock is set, nothing is written to the disk, and the run ends after that word.
- R8: Before each word, if the disk address is at or above (platters_m1 + 1) × 2^18, the engine sets err_nxd and ends the run. No memory access is made for that word, and the disk address is left unchanged.
- R9: After each word the disk address increments modulo 2^20, and da_out shows it.
- R10: The run ends with done = 1 when the incremented word count is 0. Location 07750 then holds 0.
- R11: With burst = 1, the next word's count fetch starts at most 8 cycles after the previous one. With burst = 0, each later word starts two cycles after a word_tick pulse, so exactly one word moves per tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, accepted only while idle |
| start_write | input | 1 | Direction: 1 = memory to disk, 0 = disk to memory |
| start_da | input | 20 | Disk address loaded at start |
| mex | input | 3 | Memory field number for data accesses |
| burst | input | 1 | 1 = back-to-back words, 0 = one word per tick |
| platters_m1 | input | 2 | Platter count minus one |
| wlock_mask | input | 32 | Write-lock bit per disk region |
| word_tick | input | 1 | One-cycle pulse per disk word time |
| head_pos | input | 11 | Word position currently under the head |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 15 | Physical memory address |
| mem_wdata | output | 12 | Memory write data |
| mem_rdata | input | 12 | Memory read data, valid one cycle after a read request |
| dsk_addr | output | 20 | Disk word address |
| dsk_rdata | input | 12 | Disk word at dsk_addr (combinational) |
| dsk_we | output | 1 | Disk write enable |
| dsk_wdata | output | 12 | Disk write data |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| err_wlock | output | 1 | Write hit a locked region |
| err_nxd | output | 1 | Disk address beyond capacity |
| da_out | output | 20 | Current disk address |

## Verification
The assertions check the following on every cycle:
- done and busy are never high together.
- A newly raised lock error never comes with a disk write.
- A newly raised capacity error ends the run at once.
- Every write to the pointer location follows a read of it.
- No memory write lands above the configured memory size.
- A non-burst word starts only after a tick.
- The disk address steps by one.

Only the bench's scenarios can show the rest, using a behavioural model that predicts every memory and disk write in order:
- the exact data moved and where it lands, including field wrap of the pointer and the 20-bit address wrap;
- the choice of lock bit among 32;
- the alignment of the first word to the head position;
- the word-to-word spacing.

// File: rtl/dk_pkg.sv
package dk_pkg;
    localparam int DK_DA_W        = 20;
    localparam int DK_WORD_W      = 12;
    localparam int DK_MEX_W       = 3;
    localparam int DK_TRACK_LOG   = 11;
    localparam int DK_PLATTER_LOG = 18;
    localparam int DK_PSEL_W      = 2;
    localparam int DK_LOCK_W      = 32;
    localparam int DK_WC_LOC      = 'o7750;
    localparam int DK_MA_LOC      = 'o7751;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HEAD,
        ST_GATE,
        ST_CHK,
        ST_WC_RD,
        ST_WC_WR,
        ST_MA_RD,
        ST_MA_WR,
        ST_DATA,
        ST_DWR,
        ST_NEXT
    } dk_state_e;

    typedef enum logic {
        DK_FN_READ  = 1'b0,
        DK_FN_WRITE = 1'b1
    } dk_func_e;

    typedef struct packed {
        logic wlock;
        logic nxd;
    } dk_err_t;
endpackage

// File: rtl/dk_guard.sv
module dk_guard #(
    parameter int DA_W        = dk_pkg::DK_DA_W,
    parameter int LOCK_W      = dk_pkg::DK_LOCK_W,
    parameter int PSEL_W      = dk_pkg::DK_PSEL_W,
    parameter int PLATTER_LOG = dk_pkg::DK_PLATTER_LOG,
    parameter int TRACK_LOG   = dk_pkg::DK_TRACK_LOG
) (
    input  logic [DA_W-1:0]      da,
    input  logic [PSEL_W-1:0]    platters_m1,
    input  logic [LOCK_W-1:0]    wlock_mask,
    input  logic [TRACK_LOG-1:0] head_pos,
    output logic                 beyond_cap,
    output logic                 locked,
    output logic                 at_head
);
    localparam int CAP_W = DA_W + 1;
    localparam int IDX_W = $clog2(LOCK_W);
    localparam int HI_W  = DA_W - PLATTER_LOG;
    localparam int LO_W  = IDX_W - HI_W;

    logic [CAP_W-1:0] cap;
    logic [IDX_W-1:0] idx;

    always_comb begin
        // capacity grows in whole platters
        cap        = (CAP_W'(platters_m1) + CAP_W'(1)) << PLATTER_LOG;
        beyond_cap = {1'b0, da} >= cap;
        // platter bits on top, the three bits below the skipped one beneath
        idx        = {da[DA_W-1 -: HI_W], da[PLATTER_LOG-2 -: LO_W]};
        locked     = wlock_mask[idx];
        at_head    = da[TRACK_LOG-1:0] == head_pos;
    end
endmodule

// File: rtl/dk_disk_addr.sv
module dk_disk_addr #(
    parameter int DA_W = dk_pkg::DK_DA_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [DA_W-1:0] load_val,
    input  logic            inc,
    output logic [DA_W-1:0] da
);
    always_ff @(posedge clk) begin
        if (rst)       da <= '0;
        else if (load) da <= load_val;
        else if (inc)  da <= da + 1'b1;
    end

    // R9
    da_step_chk: assert property (@(posedge clk) disable iff (rst)
        (inc && !load) |=> (da == $past(da) + DA_W'(1)));
endmodule

// File: rtl/dk_dma_engine.sv
module dk_dma_engine
    import dk_pkg::*;
#(
    parameter int DA_W        = DK_DA_W,
    parameter int WORD_W      = DK_WORD_W,
    parameter int MEX_W       = DK_MEX_W,
    parameter int TRACK_LOG   = DK_TRACK_LOG,
    parameter int PLATTER_LOG = DK_PLATTER_LOG,
    parameter int PSEL_W      = DK_PSEL_W,
    parameter int LOCK_W      = DK_LOCK_W,
    parameter int PHYS_WORDS  = 24576
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 start_write,
    input  logic [DA_W-1:0]      start_da,
    input  logic [MEX_W-1:0]     mex,
    input  logic                 burst,
    input  logic [PSEL_W-1:0]    platters_m1,
    input  logic [LOCK_W-1:0]    wlock_mask,
    input  logic                 word_tick,
    input  logic [TRACK_LOG-1:0] head_pos,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [WORD_W+MEX_W-1:0] mem_addr,
    output logic [WORD_W-1:0]    mem_wdata,
    input  logic [WORD_W-1:0]    mem_rdata,
    output logic [DA_W-1:0]      dsk_addr,
    input  logic [WORD_W-1:0]    dsk_rdata,
    output logic                 dsk_we,
    output logic [WORD_W-1:0]    dsk_wdata,
    output logic                 busy,
    output logic                 done,
    output logic                 err_wlock,
    output logic                 err_nxd,
    output logic [DA_W-1:0]      da_out
);
    localparam int PA_W = WORD_W + MEX_W;
    localparam logic [PA_W-1:0] WC_LOC = PA_W'(DK_WC_LOC);
    localparam logic [PA_W-1:0] MA_LOC = PA_W'(DK_MA_LOC);

    dk_state_e         state;
    dk_func_e          func;
    dk_err_t           err;
    logic [MEX_W-1:0]  mex_q;
    logic [WORD_W-1:0] wc_q;
    logic [WORD_W-1:0] ma_q;
    logic              done_q;
    logic [DA_W-1:0]   da;
    logic              da_load;
    logic              da_inc;
    logic              beyond_cap;
    logic              locked;
    logic              at_head;
    logic [PA_W-1:0]   pa;
    logic              pa_ok;

    assign da_load = (state == ST_IDLE) && start;
    assign pa      = {mex_q, ma_q};
    assign pa_ok   = 32'(pa) < 32'(PHYS_WORDS);

    dk_disk_addr #(.DA_W(DA_W)) u_da (
        .clk      (clk),
        .rst      (rst),
        .load     (da_load),
        .load_val (start_da),
        .inc      (da_inc),
        .da       (da)
    );

    dk_guard #(
        .DA_W        (DA_W),
        .LOCK_W      (LOCK_W),
        .PSEL_W      (PSEL_W),
        .PLATTER_LOG (PLATTER_LOG),
        .TRACK_LOG   (TRACK_LOG)
    ) u_guard (
        .da          (da),
        .platters_m1 (platters_m1),
        .wlock_mask  (wlock_mask),
        .head_pos    (head_pos),
        .beyond_cap  (beyond_cap),
        .locked      (locked),
        .at_head     (at_head)
    );

    // access decode per state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = WC_LOC;
        mem_wdata = '0;
        dsk_we    = 1'b0;
        dsk_wdata = mem_rdata;
        da_inc    = 1'b0;
        unique case (state)
            ST_WC_RD: mem_req = 1'b1;
            ST_WC_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = mem_rdata + 1'b1;
            end
            ST_MA_RD: begin
                mem_req  = 1'b1;
                mem_addr = MA_LOC;
            end
            ST_MA_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = MA_LOC;
                mem_wdata = mem_rdata + 1'b1;
            end
            ST_DATA: begin
                mem_addr = pa;
                if (func == DK_FN_WRITE) begin
                    mem_req = 1'b1;
                end else begin
                    mem_req   = pa_ok;
                    mem_we    = 1'b1;
                    mem_wdata = dsk_rdata;
                end
            end
            ST_DWR:  dsk_we = !locked;
            ST_NEXT: da_inc = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            func   <= DK_FN_READ;
            err    <= '0;
            mex_q  <= '0;
            wc_q   <= '0;
            ma_q   <= '0;
            done_q <= 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    func   <= start_write ? DK_FN_WRITE : DK_FN_READ;
                    mex_q  <= mex;
                    err    <= '0;
                    done_q <= 1'b0;
                    state  <= ST_HEAD;
                end
                ST_HEAD: if (at_head)   state <= ST_CHK;
                ST_GATE: if (word_tick) state <= ST_CHK;
                ST_CHK: begin
                    if (beyond_cap) begin
                        err.nxd <= 1'b1;
                        done_q  <= 1'b1;
                        state   <= ST_IDLE;
                    end else begin
                        state <= ST_WC_RD;
                    end
                end
                ST_WC_RD: state <= ST_WC_WR;
                ST_WC_WR: begin
                    wc_q  <= mem_rdata + 1'b1;
                    state <= ST_MA_RD;
                end
                ST_MA_RD: state <= ST_MA_WR;
                ST_MA_WR: begin
                    ma_q  <= mem_rdata + 1'b1;
                    state <= ST_DATA;
                end
                ST_DATA: state <= (func == DK_FN_WRITE) ? ST_DWR : ST_NEXT;
                ST_DWR: begin
                    if (locked) err.wlock <= 1'b1;
                    state <= ST_NEXT;
                end
                ST_NEXT: begin
                    if (wc_q == '0 || err != '0) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else begin
                        state <= burst ? ST_CHK : ST_GATE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy      = state != ST_IDLE;
    assign done      = done_q;
    assign err_wlock = err.wlock;
    assign err_nxd   = err.nxd;
    assign dsk_addr  = da;
    assign da_out    = da;

    // R2
    done_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R2
    start_take_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !done && !err_wlock && !err_nxd));

    // R7
    lock_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_wlock) |-> !$past(dsk_we));

    // R8
    nxd_stop_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_nxd) |-> (done && !busy));

    // R4
    ma_order_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MA_WR) |-> $past(mem_req && !mem_we && mem_addr == MA_LOC));

    // R6
    mem_range_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (32'(mem_addr) < 32'(PHYS_WORDS)));

    // R11
    gate_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHK && $past(state) == ST_GATE) |-> $past(word_tick));
endmodule

// File: tb/tb_dk_dma_engine.sv
module tb_dk_dma_engine;
    localparam int TICK     = 12;
    localparam int PHYS     = 24576;
    localparam int WC_LOC   = 'o7750;
    localparam int MA_LOC   = 'o7751;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        start_write = 1'b0;
    logic [19:0] start_da = '0;
    logic [2:0]  mex = '0;
    logic        burst = 1'b1;
    logic [1:0]  platters_m1 = '0;
    logic [31:0] wlock_mask = '0;
    logic        word_tick;
    logic [10:0] head_pos;
    logic        mem_req, mem_we;
    logic [14:0] mem_addr;
    logic [11:0] mem_wdata;
    logic [11:0] mem_rdata;
    logic [19:0] dsk_addr;
    logic [11:0] dsk_rdata;
    logic        dsk_we;
    logic [11:0] dsk_wdata;
    logic        busy, done, err_wlock, err_nxd;
    logic [19:0] da_out;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int div    = 0;

    logic [11:0] mem [int];
    int exp_ma[$], exp_md[$], exp_dda[$], exp_ddd[$];
    int wc_cyc[$];
    string cur_tag = "R1";
    int  tgt = 0;
    int  match_cyc = -100;
    bit  match_seen = 1'b0;

    always #2.5 clk = ~clk;

    dk_dma_engine dut (
        .clk(clk), .rst(rst), .start(start), .start_write(start_write),
        .start_da(start_da), .mex(mex), .burst(burst), .platters_m1(platters_m1),
        .wlock_mask(wlock_mask), .word_tick(word_tick), .head_pos(head_pos),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dsk_addr(dsk_addr),
        .dsk_rdata(dsk_rdata), .dsk_we(dsk_we), .dsk_wdata(dsk_wdata),
        .busy(busy), .done(done), .err_wlock(err_wlock), .err_nxd(err_nxd),
        .da_out(da_out)
    );

    function automatic logic [11:0] dpat(input int a);
        return 12'((a * 7 + 3) ^ (a >> 8));
    endfunction

    function automatic logic [11:0] mread(input int a);
        if (mem.exists(a)) return mem[a];
        return 12'(a * 5 + 1);
    endfunction

    assign dsk_rdata = dpat(int'(dsk_addr));

    // memory with registered read and disk rotation
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req) begin
            if (mem_we) mem[int'(mem_addr)] = mem_wdata;
            else        mem_rdata <= mread(int'(mem_addr));
        end
        if (rst) begin
            div <= 0; word_tick <= 1'b0; head_pos <= '0;
        end else begin
            div       <= (div == TICK - 1) ? 0 : div + 1;
            word_tick <= (div == TICK - 1);
            if (word_tick) head_pos <= head_pos + 1'b1;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // per-clock comparison against the predicted write streams
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_req && mem_we) begin : mw
                int a;
                int d;
                if (exp_ma.size() == 0) begin
                    chk(1'b0, cur_tag, "extra memory write", longint'(mem_addr), -1);
                end else begin
                    a = exp_ma.pop_front();
                    d = exp_md.pop_front();
                    chk(int'(mem_addr) == a && int'(mem_wdata) == d, cur_tag,
                        "memory write addr/data",
                        longint'(mem_addr) * 4096 + mem_wdata, longint'(a) * 4096 + d);
                end
            end
            if (dsk_we) begin : dw
                int a;
                int d;
                if (exp_dda.size() == 0) begin
                    chk(1'b0, "R7", "extra disk write", longint'(dsk_addr), -1);
                end else begin
                    a = exp_dda.pop_front();
                    d = exp_ddd.pop_front();
                    chk(int'(dsk_addr) == a && int'(dsk_wdata) == d, "R7",
                        "disk write addr/data",
                        longint'(dsk_addr) * 4096 + dsk_wdata, longint'(a) * 4096 + d);
                end
            end
            if (mem_req && !mem_we && int'(mem_addr) == WC_LOC) wc_cyc.push_back(cyc);
            if (busy && !match_seen && int'(head_pos) == tgt) begin
                match_seen = 1'b1;
                match_cyc  = cyc;
            end
        end
    end

    task automatic run_xfer(input string tag, input bit wr, input int da_hi,
                            input int fixed_low, input int wc0, input int ma0,
                            input int mx, input bit bst, input int pm1,
                            input logic [31:0] lk);
        int da0, wc, ma, da, pa, idx, cap, nw;
        bit enx, ewl;
        da0 = da_hi | ((fixed_low >= 0) ? fixed_low : ((int'(head_pos) + 5) % 2048));
        mem[WC_LOC] = 12'(wc0);
        mem[MA_LOC] = 12'(ma0);
        // behavioural prediction
        wc = wc0; ma = ma0; da = da0; enx = 0; ewl = 0; nw = 0;
        cap = (pm1 + 1) << 18;
        forever begin
            if (da >= cap) begin enx = 1; break; end
            wc = (wc + 1) % 4096; exp_ma.push_back(WC_LOC); exp_md.push_back(wc);
            ma = (ma + 1) % 4096; exp_ma.push_back(MA_LOC); exp_md.push_back(ma);
            pa = (mx << 12) | ma;
            if (!wr) begin
                if (pa < PHYS) begin exp_ma.push_back(pa); exp_md.push_back(int'(dpat(da))); end
            end else begin
                idx = (((da >> 18) & 3) << 3) | ((da >> 14) & 7);
                if (lk[idx]) ewl = 1;
                else begin exp_dda.push_back(da); exp_ddd.push_back(int'(mread(pa))); end
            end
            da = (da + 1) % (1 << 20);
            nw++;
            if (wc == 0 || ewl) break;
        end
        cur_tag = tag;
        wc_cyc.delete();
        match_seen = 1'b0;
        match_cyc = -100;
        tgt = da0 & 'h7FF;
        start_write = wr; start_da = 20'(da0); mex = 3'(mx); burst = bst;
        platters_m1 = 2'(pm1); wlock_mask = lk; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !done, "R2", "busy after start", {busy, done}, 2'b10);
        while (busy) @(negedge clk);
        chk(done == 1'b1, "R10", "done at end", done, 1);
        chk(err_nxd == enx, "R8", "err_nxd", err_nxd, enx);
        chk(err_wlock == ewl, "R7", "err_wlock", err_wlock, ewl);
        chk(int'(da_out) == da, "R9", "final disk address", da_out, da);
        chk(exp_ma.size() == 0, "R4", "missing memory writes", exp_ma.size(), 0);
        chk(exp_dda.size() == 0, "R7", "missing disk writes", exp_dda.size(), 0);
        chk(int'(mread(WC_LOC)) == wc, "R10", "count word", mread(WC_LOC), wc);
        chk(wc_cyc.size() == nw, "R4", "words started", wc_cyc.size(), nw);
        if (nw > 0 && wc_cyc.size() == nw) begin
            chk(wc_cyc[0] == match_cyc + 2, "R3", "first word vs head",
                wc_cyc[0], match_cyc + 2);
            for (int i = 1; i < nw; i++) begin
                if (bst)
                    chk(wc_cyc[i] - wc_cyc[i-1] <= 8, "R11", "burst gap",
                        wc_cyc[i] - wc_cyc[i-1], 8);
                else if (i >= 2)
                    chk(wc_cyc[i] - wc_cyc[i-1] == TICK, "R11", "tick gap",
                        wc_cyc[i] - wc_cyc[i-1], TICK);
                else
                    chk(wc_cyc[i] - wc_cyc[i-1] <= TICK, "R11", "first tick gap",
                        wc_cyc[i] - wc_cyc[i-1], TICK);
            end
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R2 watchdog actual=busy expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(done == 1'b1, "R1", "done after reset", done, 1);
        chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
        chk(err_wlock == 1'b0 && err_nxd == 1'b0, "R1", "errors after reset",
            {err_wlock, err_nxd}, 0);
        chk(mem_req == 1'b0, "R1", "idle memory port", mem_req, 0);
        // R6 read, burst, field 1
        run_xfer("R6", 1'b0, 'h12000, -1, 4091, 'o100, 1, 1'b1, 0, 32'h0);
        // R7 write, every lock bit but index 0 set
        run_xfer("R7", 1'b1, 'h20000, -1, 4092, 'o500, 0, 1'b1, 0, ~32'h1);
        // R7 write into locked region index 19
        run_xfer("R7", 1'b1, 'hAC000, -1, 4090, 'o1000, 0, 1'b1, 3, 32'h0008_0000);
        // R7 same region, all other lock bits set
        run_xfer("R7", 1'b1, 'hAC000, -1, 4094, 'o1100, 0, 1'b1, 3, ~32'h0008_0000);
        // R11 one word per tick
        run_xfer("R11", 1'b0, 'h30000, -1, 4092, 'o2000, 3, 1'b0, 0, 32'h0);
        // R5 pointer wraps within field 2
        run_xfer("R5", 1'b0, 'h00000, -1, 4093, 4094, 2, 1'b1, 0, 32'h0);
        // R6 field beyond installed memory
        run_xfer("R6", 1'b0, 'h04000, -1, 4094, 'o3000, 6, 1'b1, 0, 32'h0);
        // R8 capacity crossed mid-run
        run_xfer("R8", 1'b0, 'h3F800, 'h7FF, 4093, 'o3100, 0, 1'b1, 0, 32'h0);
        // R8 start beyond capacity
        run_xfer("R8", 1'b0, 'h40000, -1, 4090, 'o3200, 0, 1'b1, 0, 32'h0);
        // R9 address wraps at 2^20
        run_xfer("R9", 1'b0, 'hFF800, 'h7FF, 4094, 'o3300, 0, 1'b1, 3, 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule